// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate and Timeout

This block sits between a host I/O bus and the signalling side of a parallel port running in enhanced (EPP) mode. The host reaches it through a one-access-at-a-time request interface with eight byte offsets. Offset 3 starts an address cycle and offset 4 a data cycle that can be 1, 2 or 4 bytes wide. The block holds the port's data and control registers. It decides from the stored control value whether an enhanced cycle is allowed, and it runs the permitted cycles as single-byte request/acknowledge transfers to a peripheral sequencer.

Each peripheral transfer has a fixed acknowledge window. A transfer that is never acknowledged ends the access and, for enhanced cycles, sets a sticky timeout flag. The flag is shown in bit 0 of the status byte and stays set until the host clears it with a status write. The host is held off until every transfer the access needs has finished or failed, and then gets a one-cycle completion pulse along with the read data.

Top module: `epp_port_ctl`

## Requirements
- R1: After reset, control reads 0xCC, data reads 0xFF, status bit 0 reads 0, and per_req and hst_rdy are low.
- R2: A write at offset 3 (address) or 4 (data) runs only when control AND 0x2F equals 0x04. Otherwise it finishes with no peripheral transfer.
- R3: A read at offset 3 or 4 runs only when control AND 0x2F equals 0x24. Otherwise it returns ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF) with no transfer.
- R4: At offset 4, hst_size 0, 1 and 2 select 1, 2 and 4 bytes, and size 3 counts as 1 byte. Bytes travel lowest first. Write bytes come from hst_wdata[7:0] upward, and read bytes fill hst_rdata[7:0] upward.
- R5: A transfer that gets no per_ack while per_req has been high for TMO_CYCLES cycles fails. An enhanced cycle that fails sets the timeout flag and skips its remaining bytes. Read bytes that were not received return 0xFF.
- R6: The timeout flag stays set until a status write (offset 1) with bit 0 set. A status write with bit 0 clear leaves it unchanged.
- R7: A status read returns per_status[7:1] in bits 7:1 and the timeout flag in bit 0.
- R8: A data (offset 0) or control (offset 2) write whose value equals the stored one causes no peripheral transfer.
- R9: A control write that flips bit 5 (direction) sends op 2 carrying the new direction in bit 0, then op 1 carrying the new control byte with bit 5 cleared. Any other changing control write sends only op 1 with the new byte.
- R10: hst_rdy is a single-cycle pulse at the end of each access. Only one per_req is outstanding at a time, and per_req drops for at least one cycle after each acknowledge.
- R11: Control bits 7:6 always read as 1, whatever value was written.
- R12: Failed transfers for data, control or direction (ops 0, 1, 2) end the access without setting the timeout flag.
- R13: per_op codes: 0 data write, 1 control write, 2 direction, 3 address write, 4 data write (enhanced), 5 address read, 6 data read (enhanced).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access request, held until hst_rdy |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 3 | Register offset |
| hst_size | input | 2 | Width code for offset 4 |
| hst_wdata | input | 32 | Write data |
| hst_rdy | output | 1 | Access complete pulse |
| hst_rdata | output | 32 | Read data, valid with hst_rdy |
| per_req | output | 1 | Peripheral transfer request |
| per_op | output | 3 | Transfer kind (R13) |
| per_wdata | output | 8 | Byte sent to peripheral |
| per_ack | input | 1 | Transfer acknowledge |
| per_rdata | input | 8 | Byte returned with per_ack |
| per_status | input | 8 | Live peripheral status byte |

## Verification
The hardest condition to reach is a 4-byte enhanced read that times out partway through, because it needs a peripheral that acknowledges some bytes and then goes silent. The bench's peripheral model takes an acknowledge limit, counted against its running acknowledge total. Setting the limit two acknowledges ahead makes the third byte time out, and the bench then checks the partial read data, the sticky flag and its clearing. A failed direction transfer that must leave the flag clear is reached the same way, with a limit of zero before a direction-flipping control write.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [2:0] {
    OP_DATA_WR = 3'd0,
    OP_CTRL_WR = 3'd1,
    OP_DIR_SET = 3'd2,
    OP_ADDR_WR = 3'd3,
    OP_EDAT_WR = 3'd4,
    OP_ADDR_RD = 3'd5,
    OP_EDAT_RD = 3'd6
  } op_e;

  localparam logic [7:0] CTL_GATE_MASK = 8'h2F;
  localparam logic [7:0] CTL_GATE_WR   = 8'h04;
  localparam logic [7:0] CTL_GATE_RD   = 8'h24;
  localparam logic [7:0] CTL_FORCED    = 8'hC0;
  localparam logic [7:0] CTL_RESET     = 8'hCC;
  localparam logic [7:0] CTL_DIR_CLR   = 8'hDF;
  localparam int         CTL_DIR_BIT   = 5;

  typedef struct packed {
    logic [2:0]  steps;
    op_e         op;
    logic        dirchg;
    logic        is_rd;
    logic        sets_flag;
    logic [31:0] payload;
    logic [31:0] rd_init;
  } plan_t;

  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [31:0] size_ones(logic [1:0] sz);
    case (sz)
      2'd1:    return 32'h0000_FFFF;
      2'd2:    return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_pkg::*;
(
  input  logic        acc_wr,
  input  logic [2:0]  acc_addr,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  input  logic [7:0]  ctrl_q,
  input  logic [7:0]  data_q,
  input  logic [7:1]  sts_hi,
  input  logic        tmo_flag,
  output plan_t       plan,
  output logic        ctrl_we,
  output logic [7:0]  ctrl_nx,
  output logic        data_we,
  output logic        flag_clr
);

  logic [7:0] ctl_written;
  logic       wr_allowed;
  logic       rd_allowed;
  logic [1:0] epp_sz;

  always_comb begin
    ctl_written = acc_wdata[7:0] | CTL_FORCED;
    wr_allowed  = (ctrl_q & CTL_GATE_MASK) == CTL_GATE_WR;
    rd_allowed  = (ctrl_q & CTL_GATE_MASK) == CTL_GATE_RD;
    epp_sz      = (acc_addr == 3'd4) ? acc_size : 2'd0;

    plan      = '0;
    plan.op   = OP_DATA_WR;
    ctrl_we   = 1'b0;
    ctrl_nx   = ctl_written;
    data_we   = 1'b0;
    flag_clr  = 1'b0;

    case (acc_addr)
      3'd0: begin
        if (acc_wr) begin
          if (acc_wdata[7:0] != data_q) begin
            data_we      = 1'b1;
            plan.steps   = 3'd1;
            plan.op      = OP_DATA_WR;
            plan.payload = {24'h0, acc_wdata[7:0]};
          end
        end else begin
          plan.rd_init = {24'h0, data_q};
        end
      end
      3'd1: begin
        if (acc_wr) flag_clr = acc_wdata[0];
        else        plan.rd_init = {24'h0, sts_hi, tmo_flag};
      end
      3'd2: begin
        if (acc_wr) begin
          if (ctl_written != ctrl_q) begin
            ctrl_we = 1'b1;
            plan.op = OP_CTRL_WR;
            if (ctl_written[CTL_DIR_BIT] != ctrl_q[CTL_DIR_BIT]) begin
              plan.dirchg  = 1'b1;
              plan.steps   = 3'd2;
              plan.payload = {16'h0, ctl_written & CTL_DIR_CLR,
                              7'h0, ctl_written[CTL_DIR_BIT]};
            end else begin
              plan.steps   = 3'd1;
              plan.payload = {24'h0, ctl_written};
            end
          end
        end else begin
          plan.rd_init = {24'h0, ctrl_q};
        end
      end
      3'd3, 3'd4: begin
        plan.sets_flag = 1'b1;
        plan.payload   = acc_wdata;
        if (acc_wr) begin
          plan.op = (acc_addr == 3'd3) ? OP_ADDR_WR : OP_EDAT_WR;
          if (wr_allowed) plan.steps = size_bytes(epp_sz);
        end else begin
          plan.is_rd   = 1'b1;
          plan.op      = (acc_addr == 3'd3) ? OP_ADDR_RD : OP_EDAT_RD;
          plan.rd_init = size_ones(epp_sz);
          if (rd_allowed) plan.steps = size_bytes(epp_sz);
        end
      end
      default: begin
        if (!acc_wr) plan.rd_init = 32'h0000_00FF;
      end
    endcase
  end

endmodule

// File: rtl/epp_tmo_flag.sv
module epp_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_nx;

  always_comb begin
    flag_nx = flag;
    if (clr) flag_nx = 1'b0;
    if (set) flag_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nx;
  end

endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_req,
  input  plan_t       plan,
  output logic        accept,
  output logic        hst_rdy,
  output logic [31:0] hst_rdata,
  output logic        per_req,
  output logic [2:0]  per_op,
  output logic [7:0]  per_wdata,
  input  logic        per_ack,
  input  logic [7:0]  per_rdata,
  output logic        flag_set
);

  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_DONE} st_e;

  st_e         st_q, st_nx;
  logic [1:0]  idx_q, idx_nx;
  logic [TW-1:0] tmr_q, tmr_nx;
  plan_t       lat_q;
  logic        lat_en;
  logic [31:0] rbuf_q, rbuf_nx;
  logic        rbuf_en;
  logic        tmo_hit;
  logic        last_step;

  always_comb begin
    accept    = (st_q == S_IDLE) && hst_req;
    tmo_hit   = (tmr_q == TMO_LAST);
    last_step = ({1'b0, idx_q} == (lat_q.steps - 3'd1));
    per_req   = (st_q == S_XFER);
    per_op    = (lat_q.dirchg && idx_q == 2'd0) ? OP_DIR_SET : lat_q.op;
    per_wdata = lat_q.payload[{idx_q, 3'b000} +: 8];
    hst_rdy   = (st_q == S_DONE);
    hst_rdata = rbuf_q;
    flag_set  = (st_q == S_XFER) && !per_ack && tmo_hit && lat_q.sets_flag;

    st_nx   = st_q;
    idx_nx  = idx_q;
    tmr_nx  = tmr_q;
    lat_en  = 1'b0;
    rbuf_en = 1'b0;
    rbuf_nx = rbuf_q;

    case (st_q)
      S_IDLE: begin
        if (accept) begin
          lat_en  = 1'b1;
          rbuf_en = 1'b1;
          rbuf_nx = plan.rd_init;
          idx_nx  = 2'd0;
          tmr_nx  = '0;
          st_nx   = (plan.steps != 3'd0) ? S_XFER : S_DONE;
        end
      end
      S_XFER: begin
        if (per_ack) begin
          if (lat_q.is_rd) begin
            rbuf_en = 1'b1;
            rbuf_nx[{idx_q, 3'b000} +: 8] = per_rdata;
          end
          if (last_step) begin
            st_nx = S_DONE;
          end else begin
            idx_nx = idx_q + 2'd1;
            st_nx  = S_GAP;
          end
        end else if (tmo_hit) begin
          st_nx = S_DONE;
        end else begin
          tmr_nx = tmr_q + TW'(1);
        end
      end
      S_GAP: begin
        tmr_nx = '0;
        st_nx  = S_XFER;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      tmr_q  <= '0;
      lat_q  <= '0;
      rbuf_q <= '0;
    end else begin
      st_q  <= st_nx;
      idx_q <= idx_nx;
      tmr_q <= tmr_nx;
      if (lat_en)  lat_q  <= plan;
      if (rbuf_en) rbuf_q <= rbuf_nx;
    end
  end

endmodule

// File: rtl/epp_port_ctl.sv
module epp_port_ctl
  import epp_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_req,
  input  logic        hst_wr,
  input  logic [2:0]  hst_addr,
  input  logic [1:0]  hst_size,
  input  logic [31:0] hst_wdata,
  output logic        hst_rdy,
  output logic [31:0] hst_rdata,
  output logic        per_req,
  output logic [2:0]  per_op,
  output logic [7:0]  per_wdata,
  input  logic        per_ack,
  input  logic [7:0]  per_rdata,
  input  logic [7:0]  per_status
);

  logic       rst_meta_q, rst_sync_n;
  logic [7:0] ctrl_q, data_q, ctrl_nx;
  logic       ctrl_we, data_we, flag_clr, flag_set, tmo_flag, accept;
  plan_t      plan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  epp_gate u_gate (
    .acc_wr   (hst_wr),
    .acc_addr (hst_addr),
    .acc_size (hst_size),
    .acc_wdata(hst_wdata),
    .ctrl_q   (ctrl_q),
    .data_q   (data_q),
    .sts_hi   (per_status[7:1]),
    .tmo_flag (tmo_flag),
    .plan     (plan),
    .ctrl_we  (ctrl_we),
    .ctrl_nx  (ctrl_nx),
    .data_we  (data_we),
    .flag_clr (flag_clr)
  );

  epp_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hst_req  (hst_req),
    .plan     (plan),
    .accept   (accept),
    .hst_rdy  (hst_rdy),
    .hst_rdata(hst_rdata),
    .per_req  (per_req),
    .per_op   (per_op),
    .per_wdata(per_wdata),
    .per_ack  (per_ack),
    .per_rdata(per_rdata),
    .flag_set (flag_set)
  );

  epp_tmo_flag u_flag (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set  (flag_set),
    .clr  (accept && flag_clr),
    .flag (tmo_flag)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= CTL_RESET;
      data_q <= 8'hFF;
    end else begin
      if (accept && ctrl_we) ctrl_q <= ctrl_nx;
      if (accept && data_we) data_q <= hst_wdata[7:0];
    end
  end

endmodule

// File: rtl/epp_port_ctl_chk.sv
module epp_port_ctl_chk #(
  parameter int TMO_CYCLES = 64
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        hst_wr,
  input logic [2:0]  hst_addr,
  input logic [31:0] hst_wdata,
  input logic        hst_rdy,
  input logic [31:0] hst_rdata,
  input logic        per_req,
  input logic [2:0]  per_op,
  input logic        per_ack,
  input logic [7:0]  per_status,
  input logic [7:0]  ctrl_q,
  input logic        tmo_flag
);

  int unsigned req_run;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  req_run <= 0;
    else if (per_req) req_run <= req_run + 1;
    else              req_run <= 0;
  end

  assert_rdy_pulse_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hst_rdy |=> !hst_rdy);

  assert_req_gap_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (per_req && per_ack) |=> !per_req);

  assert_tmo_window_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    per_req |-> (req_run < TMO_CYCLES));

  assert_flag_after_fail_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tmo_flag) |-> ($past(per_req) && !per_req));

  assert_wr_gate_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (per_req && (per_op == 3'd3 || per_op == 3'd4)) |-> ((ctrl_q & 8'h2F) == 8'h04));

  assert_rd_gate_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (per_req && (per_op == 3'd5 || per_op == 3'd6)) |-> ((ctrl_q & 8'h2F) == 8'h24));

  assert_sts_merge_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hst_rdy && !hst_wr && hst_addr == 3'd1) |->
      (hst_rdata[7:1] == $past(per_status[7:1]) && hst_rdata[0] == tmo_flag));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hst_rdy && hst_wr && hst_addr == 3'd1 && hst_wdata[0]) |-> !tmo_flag);

  assert_op_code_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    per_req |-> (per_op != 3'd7));

endmodule

bind epp_port_ctl epp_port_ctl_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .hst_wr    (hst_wr),
  .hst_addr  (hst_addr),
  .hst_wdata (hst_wdata),
  .hst_rdy   (hst_rdy),
  .hst_rdata (hst_rdata),
  .per_req   (per_req),
  .per_op    (per_op),
  .per_ack   (per_ack),
  .per_status(per_status),
  .ctrl_q    (ctrl_q),
  .tmo_flag  (tmo_flag)
);

// File: tb/epp_port_ctl_test.sv
module epp_port_ctl_test;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0, hst_wr = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [1:0]  hst_size = '0;
  logic [31:0] hst_wdata = '0;
  logic        hst_rdy;
  logic [31:0] hst_rdata;
  logic        per_req;
  logic [2:0]  per_op;
  logic [7:0]  per_wdata;
  logic        per_ack;
  logic [7:0]  per_rdata;
  logic [7:0]  per_status = 8'hA5;

  int n_chk = 0, n_bad = 0;
  int log_n = 0, ack_limit = -1, wcnt = 0, req_hi = 0;
  logic [2:0] log_op [0:255];
  logic [7:0] log_dat [0:255];

  always #5 clk = ~clk;

  epp_port_ctl #(.TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_size(hst_size), .hst_wdata(hst_wdata),
    .hst_rdy(hst_rdy), .hst_rdata(hst_rdata), .per_req(per_req),
    .per_op(per_op), .per_wdata(per_wdata), .per_ack(per_ack),
    .per_rdata(per_rdata), .per_status(per_status)
  );

  // peripheral model: acks after one idle cycle, up to ack_limit total acks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_ack <= 1'b0;
      per_rdata <= 8'h00;
      wcnt <= 0;
    end else begin
      per_ack <= 1'b0;
      if (per_req && !per_ack) begin
        if (wcnt >= 1 && (ack_limit < 0 || log_n < ack_limit)) begin
          per_ack <= 1'b1;
          per_rdata <= 8'h30 + 8'(log_n);
          log_op[log_n[7:0]] <= per_op;
          log_dat[log_n[7:0]] <= per_wdata;
          log_n <= log_n + 1;
          wcnt <= 0;
        end else begin
          wcnt <= wcnt + 1;
        end
      end else if (!per_req) begin
        wcnt <= 0;
      end
    end
  end

  always @(posedge clk) if (per_req) req_hi <= req_hi + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd);
    int k;
    @(negedge clk);
    hst_wr = wr; hst_addr = a; hst_size = sz; hst_wdata = wd; hst_req = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!hst_rdy && k < 500);
    rd = hst_rdata;
    hst_req = 1'b0;
    if (!hst_rdy) check("R10 access never completed", 32'h0, 32'h1);
    @(negedge clk);
    check("R10 rdy single pulse", {31'h0, hst_rdy}, 32'h0);
  endtask

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  nx;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VECS [0:17] = '{
    '{1'b0, 3'd2, 2'd0, 32'h0,        32'h0000_00CC, 4'd0, 4'd1},  // R1 control reset
    '{1'b0, 3'd0, 2'd0, 32'h0,        32'h0000_00FF, 4'd0, 4'd1},  // R1 data reset
    '{1'b1, 3'd0, 2'd0, 32'h5A,       32'h0,         4'd1, 4'd8},  // R8 new data sent
    '{1'b1, 3'd0, 2'd0, 32'h5A,       32'h0,         4'd0, 4'd8},  // R8 repeat suppressed
    '{1'b0, 3'd0, 2'd0, 32'h0,        32'h0000_005A, 4'd0, 4'd8},
    '{1'b1, 3'd3, 2'd0, 32'h11,       32'h0,         4'd0, 4'd2},  // R2 gated off
    '{1'b0, 3'd3, 2'd0, 32'h0,        32'h0000_00FF, 4'd0, 4'd3},  // R3 ones
    '{1'b0, 3'd4, 2'd2, 32'h0,        32'hFFFF_FFFF, 4'd0, 4'd3},
    '{1'b0, 3'd4, 2'd1, 32'h0,        32'h0000_FFFF, 4'd0, 4'd3},
    '{1'b1, 3'd2, 2'd0, 32'h04,       32'h0,         4'd1, 4'd9},  // R9 single op
    '{1'b0, 3'd2, 2'd0, 32'h0,        32'h0000_00C4, 4'd0, 4'd11}, // R11
    '{1'b1, 3'd2, 2'd0, 32'h04,       32'h0,         4'd0, 4'd8},
    '{1'b1, 3'd4, 2'd1, 32'hBEEF,     32'h0,         4'd2, 4'd4},  // R4 two bytes
    '{1'b1, 3'd3, 2'd2, 32'h77,       32'h0,         4'd1, 4'd2},  // R2 address one byte
    '{1'b0, 3'd4, 2'd0, 32'h0,        32'h0000_00FF, 4'd0, 4'd3},
    '{1'b1, 3'd2, 2'd0, 32'h0D,       32'h0,         4'd1, 4'd2},
    '{1'b1, 3'd4, 2'd0, 32'h99,       32'h0,         4'd0, 4'd2},
    '{1'b0, 3'd1, 2'd0, 32'h0,        32'h0000_00A4, 4'd0, 4'd7}   // R7
  };

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base, h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 per_req idle", {31'h0, per_req}, 32'h0);
    check("R1 rdy idle", {31'h0, hst_rdy}, 32'h0);

    for (int i = 0; i < 18; i++) begin
      base = log_n;
      acc(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd);
      if (!VECS[i].wr)
        check($sformatf("R%0d vector %0d rdata", VECS[i].rq, i), rd, VECS[i].exp);
      check($sformatf("R%0d vector %0d transfers", VECS[i].rq, i),
            32'(log_n - base), 32'(VECS[i].nx));
    end

    // R4 little-endian write, 4 bytes, op 4
    acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
    base = log_n;
    acc(1'b1, 3'd4, 2'd2, 32'h4433_2211, rd);
    check("R4 byte count", 32'(log_n - base), 32'd4);
    for (int b = 0; b < 4; b++) begin
      check("R4 byte order", {24'h0, log_dat[base + b]}, 32'(8'h11 * (b + 1)));
      check("R13 op data write", {29'h0, log_op[base + b]}, 32'd4);
    end

    // R9 direction change ordering
    base = log_n;
    acc(1'b1, 3'd2, 2'd0, 32'h24, rd);
    check("R9 two transfers", 32'(log_n - base), 32'd2);
    check("R9 first op direction", {29'h0, log_op[base]}, 32'd2);
    check("R9 direction value", {24'h0, log_dat[base]}, 32'h01);
    check("R9 second op control", {29'h0, log_op[base + 1]}, 32'd1);
    check("R9 control byte", {24'h0, log_dat[base + 1]}, 32'hC4);
    acc(1'b0, 3'd2, 2'd0, 32'h0, rd);
    check("R11 control readback", rd, 32'hE4);

    // R3/R4 enhanced reads
    base = log_n;
    acc(1'b0, 3'd4, 2'd2, 32'h0, rd);
    check("R4 read assembly", rd, {8'(8'h33 + base), 8'(8'h32 + base),
                                   8'(8'h31 + base), 8'(8'h30 + base)});
    base = log_n;
    acc(1'b0, 3'd3, 2'd2, 32'h0, rd);
    check("R3 address read", rd, {24'h0, 8'(8'h30 + base)});
    check("R13 op address read", {29'h0, log_op[base]}, 32'd5);

    // R5 timeout, R6 sticky, R7 merge
    ack_limit = log_n;
    h0 = req_hi;
    acc(1'b0, 3'd4, 2'd0, 32'h0, rd);
    check("R5 timed-out read data", rd, 32'hFF);
    check("R5 request window", 32'(req_hi - h0), 32'(TMO));
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check("R7 status with flag", rd, 32'hA5);
    acc(1'b1, 3'd1, 2'd0, 32'hFE, rd);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check("R6 flag survives bit0=0 write", rd, 32'hA5);
    acc(1'b1, 3'd1, 2'd0, 32'h01, rd);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check("R6 flag cleared", rd, 32'hA4);

    // R5 partial multi-byte read
    base = log_n;
    ack_limit = log_n + 2;
    h0 = req_hi;
    acc(1'b0, 3'd4, 2'd2, 32'h0, rd);
    check("R5 partial read", rd, {16'hFFFF, 8'(8'h31 + base), 8'(8'h30 + base)});
    check("R5 transfers stop at failure", 32'(log_n - base), 32'd2);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check("R5 flag set by partial", rd, 32'hA5);
    acc(1'b1, 3'd1, 2'd0, 32'h01, rd);

    // R12 failed direction transfer leaves flag clear
    ack_limit = log_n;
    h0 = req_hi;
    acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
    check("R12 single failed request", 32'(req_hi - h0), 32'(TMO));
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check("R12 flag not set", rd, 32'hA4);
    acc(1'b0, 3'd2, 2'd0, 32'h0, rd);
    check("R12 control updated", rd, 32'hC4);

    // R1 reset clears flag and registers
    acc(1'b1, 3'd3, 2'd0, 32'h55, rd);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check("R1 flag set before reset", rd, 32'hA5);
    ack_limit = -1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 per_req after reset", {31'h0, per_req}, 32'h0);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check("R1 flag after reset", rd, 32'hA4);
    acc(1'b0, 3'd2, 2'd0, 32'h0, rd);
    check("R1 control after reset", rd, 32'hCC);
    acc(1'b0, 3'd0, 2'd0, 32'h0, rd);
    check("R1 data after reset", rd, 32'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule